// File: doc/BRIEF.md
# Bit RAM with Emulated Two-Cell Bridging Fault

This block is a 256-cell, single-bit-wide storage array laid out as 16 rows of 16 columns. It emulates one OR-type bridge between two cells whose addresses are supplied on two configuration inputs. The bridge is not always active. Particular write operations turn it on or off at run time, depending on the values the two cells hold just before the write. While the bridge is active, a read of either bridged cell returns the OR of both cells.

A tracker follows the state of the fault. A sticky flag records that a read was issued while the fault was active, which means a test sequence would have observed it. A memory test sequencer drives the operation and address ports. It then checks the read data and the coverage flag, which shows whether the sequence reached this fault. If both configured addresses are equal, the block behaves as a fault-free RAM.

Top module: `bridge_fault_ram`

## Requirements
- R1: After reset, read data, the sensitized indicator and the covered flag are 0, and every cell holds 0.
- R2: Operation codes are 00 = idle, 01 = read, 10 = write-0 and 11 = write-1. The address is row*16+column, with the row in bits [7:4]. A write stores its bit in the addressed cell. A read presents the bit on the read data output after the next rising edge, and the output holds until the next read.
- R3: With the fault idle and both bridged cells at 0, a write-1 to either bridged cell sets the sensitized indicator at that edge.
- R4: With the fault idle and both bridged cells at 1, a write-0 to either bridged cell sets the sensitized indicator at that edge.
- R5: The fault returns to idle on four writes: write-0 to a at (a,b)=(1,0), write-0 to b at (0,1), write-1 to a at (0,1), and write-1 to b at (1,0). Any other write to a bridged cell leaves the state unchanged. All conditions use the cell values before the write.
- R6: While sensitized, a read of cell a or cell b returns a OR b. The stored bits are not altered, so each cell reads back its own value once the fault is idle again.
- R7: Reads, idle cycles and writes to cells other than a or b never change the sensitized indicator.
- R8: A read issued while the fault is sensitized sets the covered flag at that edge. A read while the fault is idle does not.
- R9: The covered flag stays set until the synchronous clear input is high at an edge. Clear takes priority over a read that would set the flag in the same cycle.
- R10: When the two configured addresses are equal, no fault behaviour occurs, and an active fault drops to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | Operation code (R2) |
| addr_i | input | 8 | Cell address |
| bridge_a_i | input | 8 | Address of bridged cell a |
| bridge_b_i | input | 8 | Address of bridged cell b |
| cov_clr_i | input | 1 | Synchronous clear of the covered flag |
| rdata_o | output | 1 | Registered read data |
| sens_o | output | 1 | Fault currently sensitized |
| covered_o | output | 1 | Sticky: a read occurred while sensitized |

## Verification
The bench drives the fault through all four desensitizing writes. It also drives the writes that look similar but must hold the state, for example a write-1 to a at (0,1) against a write-1 to b at (0,1). A tracker that compared the wrong pair of cells would toggle at the wrong moment. It reads the partner cell after a sensitizing write, because a design that stored the OR instead of masking it would return wrong values once the fault went idle. The bench also asserts clear in the same cycle as a covering read, changes the configuration to equal addresses while the fault is active, and issues reads while the fault is idle. In those cases, a flag that latched on reads of bridged cells regardless of state, or a tracker that ignored the configuration, would show up.

// File: rtl/bfr_pkg.sv
// Package: shared operation encoding for the bridged-fault RAM.
// Assumes a 2-bit operation field driven by the tester.
package bfr_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_READ = 2'b01,
        OP_WR0  = 2'b10,
        OP_WR1  = 2'b11
    } bfr_op_t;
endpackage

// File: rtl/bfr_array.sv
// Module: bit storage array, one register row per generate iteration.
// Writes land at the clock edge; three combinational taps expose the
// addressed cell and both bridged cells. Assumes ROWS*COLS is a power of 2.
module bfr_array #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int CELLS  = ROWS * COLS,
    localparam int ADDR_W = $clog2(CELLS),
    localparam int COL_W  = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] tap_a,
    input  logic [ADDR_W-1:0] tap_b,
    output logic              cell_x,
    output logic              cell_a,
    output logic              cell_b
);
    logic [CELLS-1:0] bits;
    logic [ADDR_W-COL_W-1:0] wr_row;
    logic [COL_W-1:0]        wr_col;

    assign wr_row = addr[ADDR_W-1:COL_W];
    assign wr_col = addr[COL_W-1:0];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Row register: cleared on reset, one bit replaced on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[r*COLS +: COLS] <= '0;
            else if (wr_en && (wr_row == r[ADDR_W-COL_W-1:0]))
                bits[r*COLS + int'(wr_col)] <= wr_bit;
        end
    end

    assign cell_x = bits[addr];
    assign cell_a = bits[tap_a];
    assign cell_b = bits[tap_b];
endmodule

// File: rtl/bfr_tracker.sv
// Module: sensitization state of the OR-type bridge between cells a and b.
// Conditions use the cell values before the write (va, vb). Assumes the
// caller forces fault_en low when a and b coincide.
module bfr_tracker
    import bfr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bfr_op_t           op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              fault_en,
    input  logic              va,
    input  logic              vb,
    output logic              sens
);
    logic is_wr, wv, hit_a, hit_b, sens_nxt;

    assign is_wr = (op == OP_WR0) || (op == OP_WR1);
    assign wv    = (op == OP_WR1);
    assign hit_a = (addr == a_addr);
    assign hit_b = (addr == b_addr);

    // Next-state: sensitize on a differing write to an equal pair,
    // desensitize when a write makes an unequal pair equal.
    always_comb begin
        sens_nxt = sens;
        if (!fault_en) begin
            sens_nxt = 1'b0;
        end else if (is_wr && (hit_a || hit_b)) begin
            if (va == vb) begin
                if (wv != va) sens_nxt = 1'b1;
            end else if (hit_a) begin
                if (wv == vb) sens_nxt = 1'b0;
            end else begin
                if (wv == va) sens_nxt = 1'b0;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) sens <= 1'b0;
        else        sens <= sens_nxt;
    end
endmodule

// File: rtl/bfr_cov.sv
// Module: sticky coverage flag. Set by a read while sensitized; a
// synchronous clear wins over a set in the same cycle.
module bfr_cov (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic sens,
    input  logic clr,
    output logic covered
);
    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)           covered <= 1'b0;
        else if (clr)         covered <= 1'b0;
        else if (rd && sens)  covered <= 1'b1;
    end
endmodule

// File: rtl/bridge_fault_ram.sv
// Module: top of the bit RAM with one emulated OR-type bridging fault.
// Composes storage, fault tracker and coverage flag; registers read data.
// Assumes the bridge addresses are stable around the operations that use them.
module bridge_fault_ram
    import bfr_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int ADDR_W = $clog2(ROWS * COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] bridge_a_i,
    input  logic [ADDR_W-1:0] bridge_b_i,
    input  logic              cov_clr_i,
    output logic              rdata_o,
    output logic              sens_o,
    output logic              covered_o
);
    bfr_op_t op;
    logic    fault_en, is_rd, is_wr, cell_x, cell_a, cell_b, bridged, rd_val;

    assign op       = bfr_op_t'(op_i);
    assign fault_en = (bridge_a_i != bridge_b_i);
    assign is_rd    = (op == OP_READ);
    assign is_wr    = (op == OP_WR0) || (op == OP_WR1);
    assign bridged  = fault_en && sens_o &&
                      ((addr_i == bridge_a_i) || (addr_i == bridge_b_i));

    bfr_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (is_wr),
        .wr_bit (op == OP_WR1),
        .addr   (addr_i),
        .tap_a  (bridge_a_i),
        .tap_b  (bridge_b_i),
        .cell_x (cell_x),
        .cell_a (cell_a),
        .cell_b (cell_b)
    );

    bfr_tracker #(.ADDR_W(ADDR_W)) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .addr     (addr_i),
        .a_addr   (bridge_a_i),
        .b_addr   (bridge_b_i),
        .fault_en (fault_en),
        .va       (cell_a),
        .vb       (cell_b),
        .sens     (sens_o)
    );

    bfr_cov u_cov (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (is_rd),
        .sens    (sens_o),
        .clr     (cov_clr_i),
        .covered (covered_o)
    );

    // Read value: OR of the bridged pair while sensitized, else the cell.
    always_comb begin
        rd_val = bridged ? (cell_a | cell_b) : cell_x;
    end

    // Read data register: one cycle of latency, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_o <= 1'b0;
        else if (is_rd) rdata_o <= rd_val;
    end
endmodule

// File: rtl/bfr_checker.sv
// Module: protocol checks for bridge_fault_ram, bound to every instance.
module bfr_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] a_addr,
    input logic [ADDR_W-1:0] b_addr,
    input logic              clr,
    input logic              va,
    input logic              vb,
    input logic              sens,
    input logic              covered
);
    // R3
    sens_on_wr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_addr != b_addr && op == 2'b11 && addr == a_addr && !va && !vb) |=> sens);
    // R4
    sens_on_wr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_addr != b_addr && op == 2'b10 && addr == b_addr && va && vb) |=> sens);
    // R5
    desens_wr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_addr != b_addr && op == 2'b10 && addr == a_addr && va && !vb) |=> !sens);
    // R7
    sens_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_addr != b_addr && (op[1] == 1'b0 || (addr != a_addr && addr != b_addr)))
        |=> $stable(sens));
    // R8
    cover_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01 && sens && !clr) |=> covered);
    // R9
    cover_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (covered && !clr) |=> covered);
    // R9
    cover_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !covered);
    // R10
    same_addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_addr == b_addr) |=> !sens);
endmodule

bind bridge_fault_ram bfr_checker #(.ADDR_W(ADDR_W)) u_bfr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op_i),
    .addr    (addr_i),
    .a_addr  (bridge_a_i),
    .b_addr  (bridge_b_i),
    .clr     (cov_clr_i),
    .va      (cell_a),
    .vb      (cell_b),
    .sens    (sens_o),
    .covered (covered_o)
);

// File: tb/bridge_fault_ram_bench.sv
`timescale 1ns/100ps
// Directed bench: one task per scenario, each checking its own results.
module bridge_fault_ram_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] addr = '0;
    logic [7:0] ba = '0;
    logic [7:0] bb = '0;
    logic       clr = 1'b0;
    logic       rdata, sens, covered;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    localparam logic [1:0] IDLE = 2'b00, RD = 2'b01, W0 = 2'b10, W1 = 2'b11;

    always #2.5 clk = ~clk;

    bridge_fault_ram u_bridge_fault_ram (
        .clk(clk), .rst_n(rst_n), .op_i(op), .addr_i(addr),
        .bridge_a_i(ba), .bridge_b_i(bb), .cov_clr_i(clr),
        .rdata_o(rdata), .sens_o(sens), .covered_o(covered)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one operation for exactly one cycle; returns at the next negedge.
    task automatic apply(input logic [1:0] o, input logic [7:0] ad, input logic c = 1'b0);
        op = o; addr = ad; clr = c;
        @(posedge clk);
        #1 op = IDLE; clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_chk(input string req, input logic [7:0] ad, input logic exp);
        apply(RD, ad);
        chk(req, rdata, exp);
    endtask

    task automatic t_reset();
        chk("R1 rdata", rdata, 1'b0);
        chk("R1 sens", sens, 1'b0);
        chk("R1 covered", covered, 1'b0);
        read_chk("R1 cell 0x55", 8'h55, 1'b0);
        read_chk("R1 cell 0xFF", 8'hFF, 1'b0);
    endtask

    task automatic t_plain();
        ba = 8'h40; bb = 8'h40;   // equal: fault off
        apply(W1, 8'h00); apply(W1, 8'h3C); apply(W1, 8'hFF);
        read_chk("R2 w1 0x00", 8'h00, 1'b1);
        read_chk("R2 untouched 0x01", 8'h01, 1'b0);
        read_chk("R2 w1 0x3C", 8'h3C, 1'b1);
        apply(IDLE, 8'h00);
        chk("R2 hold", rdata, 1'b1);
        apply(W0, 8'h3C);
        read_chk("R2 w0 0x3C", 8'h3C, 1'b0);
        read_chk("R2 w1 0xFF", 8'hFF, 1'b1);
        apply(W1, 8'h40);
        chk("R10 no sens on equal addr", sens, 1'b0);
        apply(W0, 8'h40);
    endtask

    task automatic t_sens_w1();
        ba = 8'h12; bb = 8'hE7;
        read_chk("R8 idle read a", 8'h12, 1'b0);
        chk("R8 idle read no cover", covered, 1'b0);
        apply(W1, 8'h12);
        chk("R3 wr1 a sensitizes", sens, 1'b1);
        read_chk("R6 read b gives OR", 8'hE7, 1'b1);
        chk("R8 covered after read", covered, 1'b1);
        read_chk("R6 read a gives OR", 8'h12, 1'b1);
        apply(W1, 8'h12);
        chk("R5 wr1 a at (1,0) holds", sens, 1'b1);
        apply(W1, 8'h99); apply(RD, 8'h99); apply(IDLE, 8'h12);
        chk("R7 other ops hold", sens, 1'b1);
        apply(W0, 8'h12);
        chk("R5 wr0 a at (1,0) clears", sens, 1'b0);
        read_chk("R6 b stored 0", 8'hE7, 1'b0);
        read_chk("R6 a stored 0", 8'h12, 1'b0);
        apply(W1, 8'hE7);
        chk("R3 wr1 b sensitizes", sens, 1'b1);
        apply(W1, 8'hE7);
        chk("R5 wr1 b at (0,1) holds", sens, 1'b1);
        apply(W0, 8'hE7);
        chk("R5 wr0 b at (0,1) clears", sens, 1'b0);
        apply(W1, 8'hE7);
        apply(W1, 8'h12);
        chk("R5 wr1 a at (0,1) clears", sens, 1'b0);
    endtask

    task automatic t_sens_w0();
        // cells now (1,1), fault idle
        apply(IDLE, 8'h00, 1'b1);
        chk("R9 clear", covered, 1'b0);
        read_chk("R8 idle read of (1,1)", 8'hE7, 1'b1);
        chk("R8 idle read no cover", covered, 1'b0);
        apply(W0, 8'hE7);
        chk("R4 wr0 b sensitizes", sens, 1'b1);
        read_chk("R6 read b gives OR", 8'hE7, 1'b1);
        apply(IDLE, 8'h00);
        chk("R9 sticky", covered, 1'b1);
        apply(W1, 8'hE7);
        chk("R5 wr1 b at (1,0) clears", sens, 1'b0);
        apply(W0, 8'h12);
        chk("R4 wr0 a sensitizes", sens, 1'b1);
        apply(IDLE, 8'h00, 1'b1);
        apply(RD, 8'h12, 1'b1);
        chk("R9 clear beats set", covered, 1'b0);
        chk("R6 read a gives OR", rdata, 1'b1);
        bb = 8'h12;
        apply(IDLE, 8'h00);
        chk("R10 equal addr drops sens", sens, 1'b0);
        bb = 8'hE7;
        read_chk("R10 a own value", 8'h12, 1'b0);
        chk("R8 no cover when idle", covered, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_sens_w1();
        t_sens_w0();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule